// File: doc/BRIEF.md
# Cycle-Register Multi-Duty PWM Timer

This block is one timer channel that produces several pulse-width-modulated outputs from a single up-counter. There are four compare registers. A select field names one of them as the cycle register. When the counter reaches the cycle register's value, the counter clears. The other compare registers act as duty points, one output pin each. When the counter is cleared, every duty pin returns to its programmed initial level. When the counter meets a pin's duty value, that pin moves to its programmed match level. All pins share one counter, so they all start their period at the same moment. Outputs differ only in where they switch and in their polarity.

Software programs the block through a plain register write port. Writes are taken on any cycle in which `wr_en` is high. The port has no ready signal and never stalls. The channel is normally set up while disabled, and only then is it enabled. While the channel is disabled, the counter rests at zero and the duty pins rest at their initial levels. The output pin whose compare register is serving as the cycle register carries no waveform.

Top module: `pwm_cycle_timer`

## Requirements
- R1: After reset, all compare registers, levels, the select field and the enable bit are zero, and every pin of `pwm_o` is 0.
- R2: Register writes are decoded from `wr_addr`:
  - addresses 0 to 3 load compare registers 0 to 3 from `wr_data`;
  - address 4 loads the control register, with the cycle select in bits 1:0 and the enable in bit 2;
  - address 5 loads the levels, with the initial level of pin i in bit i and the match level of pin i in bit 4+i;
  - writes to addresses 6 and 7 change nothing.
- R3: While the channel is enabled, the 16-bit counter counts up by one per clock. On the clock after it equals the cycle value P, it restarts from 0, which gives a period of P+1 clocks.
- R4: On the clock after the cycle match, every duty pin takes its initial level.
- R5: For a duty value d < P, a pin takes its match level on the clock after the counter equals d. It therefore holds the match level while the counter is in d+1..P, and the initial level while the counter is in 0..d.
- R6: A pin whose duty value equals P never leaves its initial level. A duty value above P is never reached, so that pin also stays at its initial level.
- R7: The pin whose index equals the cycle select is driven 0 at all times.
- R8: While the channel is disabled, the counter is held at 0, and each duty pin takes its initial level on the following clock. After the channel is enabled, the first period starts from counter 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, always accepted |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| pwm_o | output | 4 | PWM pins, one per compare register |

## Verification
On every cycle, the assertions check four things: the counter steps by one or clears exactly at the cycle match, it rests at zero while disabled, each pin reloads its initial level at a clear, and a pin whose duty equals the cycle value never moves between clears. Writes to unmapped addresses are also checked to leave the registers untouched. Only the bench's scenarios can show the full waveform of each pin, clock by clock, against an arithmetic model of period and duty. These scenarios sweep every cycle select, several periods including zero, and duties at 0, mid-period, equal to the period and beyond it. The bench also covers the return to initial levels after disable, and equal initial and match levels.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_LVL  = 3'd5;
endpackage

// File: rtl/pwmt_regs.sv
module pwmt_regs
  import pwmt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int N_CMP = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [CNT_W-1:0]              wr_data,
  output logic [N_CMP-1:0][CNT_W-1:0]   cmp_o,
  output logic [$clog2(N_CMP)-1:0]      sel_o,
  output logic                          en_o,
  output logic [N_CMP-1:0]              init_o,
  output logic [N_CMP-1:0]              match_o
);
  localparam int SEL_W = $clog2(N_CMP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_o   <= '0;
      sel_o   <= '0;
      en_o    <= 1'b0;
      init_o  <= '0;
      match_o <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < N_CMP; i++) begin
        if (wr_addr == ADDR_W'(i)) cmp_o[i] <= wr_data;
      end
      if (wr_addr == ADDR_CTRL) begin
        sel_o <= wr_data[SEL_W-1:0];
        en_o  <= wr_data[SEL_W];
      end
      if (wr_addr == ADDR_LVL) begin
        init_o  <= wr_data[N_CMP-1:0];
        match_o <= wr_data[2*N_CMP-1:N_CMP];
      end
    end
  end

  AST_UNMAPPED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr > ADDR_LVL) |=> ($stable(cmp_o) && $stable(sel_o) && $stable(en_o)
                                       && $stable(init_o) && $stable(match_o))); // R2
endmodule

// File: rtl/pwmt_counter.sv
module pwmt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [CNT_W-1:0] cyc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             clr_o
);
  assign clr_o = en_i && (cnt_o == cyc_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_o <= '0;
    else if (!en_i)  cnt_o <= '0;
    else if (clr_o)  cnt_o <= '0;
    else             cnt_o <= cnt_o + 1'b1;
  end

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && cnt_o == cyc_i) |=> (cnt_o == '0)); // R3
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && cnt_o != cyc_i) |=> (cnt_o == CNT_W'($past(cnt_o) + 1'b1))); // R3
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i) |=> (cnt_o == '0)); // R8
endmodule

// File: rtl/pwmt_pin.sv
module pwmt_pin #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [CNT_W-1:0] cyc_i,
  input  logic             is_cycle_i,
  input  logic             lvl_init_i,
  input  logic             lvl_match_i,
  output logic             pin_o
);
  logic lvl_q;
  logic hit;

  assign hit = (cnt_i == duty_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lvl_q <= 1'b0;
    else if (!en_i)  lvl_q <= lvl_init_i;
    else if (clr_i)  lvl_q <= lvl_init_i;
    else if (hit)    lvl_q <= lvl_match_i;
  end

  assign pin_o = is_cycle_i ? 1'b0 : lvl_q;

  AST_CLEAR_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !is_cycle_i && $stable(is_cycle_i)) |=> (pin_o == $past(lvl_init_i))); // R4
  AST_EQUAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !clr_i && duty_i == cyc_i && $stable(is_cycle_i)) |=> $stable(pin_o)); // R6
endmodule

// File: rtl/pwm_cycle_timer.sv
module pwm_cycle_timer
  import pwmt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int N_CMP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [N_CMP-1:0]  pwm_o
);
  localparam int SEL_W = $clog2(N_CMP);

  logic [N_CMP-1:0][CNT_W-1:0] cmp;
  logic [SEL_W-1:0]            sel;
  logic                        en;
  logic [N_CMP-1:0]            lvl_init;
  logic [N_CMP-1:0]            lvl_match;
  logic [CNT_W-1:0]            cyc;
  logic [CNT_W-1:0]            cnt;
  logic                        clr;

  pwmt_regs #(.CNT_W(CNT_W), .N_CMP(N_CMP)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cmp_o(cmp), .sel_o(sel), .en_o(en), .init_o(lvl_init), .match_o(lvl_match)
  );

  assign cyc = cmp[sel];

  pwmt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en_i(en), .cyc_i(cyc), .cnt_o(cnt), .clr_o(clr)
  );

  for (genvar g = 0; g < N_CMP; g++) begin : g_pin
    pwmt_pin #(.CNT_W(CNT_W)) u_pin (
      .clk(clk), .rst_n(rst_n), .en_i(en), .clr_i(clr), .cnt_i(cnt),
      .duty_i(cmp[g]), .cyc_i(cyc), .is_cycle_i(sel == SEL_W'(g)),
      .lvl_init_i(lvl_init[g]), .lvl_match_i(lvl_match[g]), .pin_o(pwm_o[g])
    );
  end
endmodule

// File: tb/tb_pwm_cycle_timer.sv
module tb_pwm_cycle_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0] pwm_o;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pwm_cycle_timer dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_o(pwm_o)
  );

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // R3 R4 R5 R6 R7: per-clock model, counter = k mod (P+1)
  task automatic run_cfg(input int sel, input int p, input int d[4],
                         input logic [3:0] ini, input logic [3:0] mat);
    bit bad[4];
    logic [3:0] fa, fe;
    wr(3'd4, 16'(sel));            // disable, pick select
    for (int i = 0; i < 4; i++) wr(3'(i), 16'(i == sel ? p : d[i]));
    wr(3'd5, {8'h00, mat, ini});
    wr(3'd6, 16'hFFFF);            // R2: unmapped, must not disturb
    wr(3'd7, 16'h0003);
    for (int i = 0; i < 4; i++) bad[i] = 0;
    fa = '0; fe = '0;
    wr(3'd4, 16'(4 | sel));        // enable; now at sample k=0
    for (int k = 0; k < 3 * (p + 1) + 2; k++) begin
      int c;
      logic [3:0] e;
      c = k % (p + 1);
      for (int i = 0; i < 4; i++) begin
        if (i == sel)                   e[i] = 1'b0;
        else if (d[i] < p && c > d[i])  e[i] = mat[i];
        else                            e[i] = ini[i];
      end
      for (int i = 0; i < 4; i++) if (pwm_o[i] !== e[i] && !bad[i]) begin
        bad[i] = 1; fa = pwm_o; fe = e;
      end
      @(negedge clk);
    end
    for (int i = 0; i < 4; i++) begin
      string r;
      if (i == sel)       r = "R7";
      else if (d[i] < p)  r = "R3/R4/R5/R2";
      else                r = "R6";
      tests++;
      if (bad[i]) begin
        fails++;
        $display("FAIL %s sel=%0d P=%0d pin=%0d d=%0d actual=%b expected=%b",
                 r, sel, p, i, d[i], fa, fe);
      end
    end
    // R8: disable returns duty pins to initial levels
    wr(3'd4, 16'(sel));
    @(negedge clk);
    begin
      logic [3:0] m;
      m = ini;
      m[sel] = 1'b0;
      chk("R8 disabled", pwm_o, m);
    end
  endtask

  initial begin
    #2ms;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int cfg = 0;
    int plist[3] = '{0, 3, 6};
    repeat (3) @(negedge clk);
    chk("R1 reset", pwm_o, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", pwm_o, 4'b0000);
    for (int s = 0; s < 4; s++) begin
      for (int pi = 0; pi < 3; pi++) begin
        int p, m;
        int pool[4];
        int d[4];
        logic [3:0] ini, mat;
        p = plist[pi];
        pool = '{0, p / 2 + 1, p, p + 2};
        m = 0;
        for (int i = 0; i < 4; i++) begin
          if (i == s) d[i] = 0;
          else begin d[i] = pool[(m + cfg) % 4]; m++; end
        end
        ini = 4'(cfg * 5);
        mat = (cfg % 5 == 0) ? ini : ~ini;
        run_cfg(s, p, d, ini, mat);
        cfg++;
      end
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule